// File: doc/BRIEF.md
# Interleaved Multibank Load Controller

This block takes word load requests from a processor-side port and sends each one to one of `NB` independent memory banks. The bank is chosen from the low bits of the word address, and the remaining bits form the row inside that bank. Several loads can be in flight at once, so the controller starts loads to other banks before the first result has come back. Each bank keeps its own recovery timer after an access. A request whose bank is still recovering is held at the port with `req_ready` low. That wait is a bank stall, and every stalled cycle is added to a running counter.

Every bank returns its word a fixed `LAT` cycles after it is read. The controller picks that word off the bank's data lane and presents it on the response port with the tag of the original request. Because the latency is fixed, responses leave in issue order. The number of loads in flight is capped at `MAX_OUT`. A load that retires in the same cycle as a new issue frees its slot for that issue, so a full window does not cost a bubble. Unit-stride and other-stride address streams use the same path. Only the bank-conflict pattern differs between them, and the stall counter reports it.

Top module: `imb_ctrl`

## Requirements
- R1: The bank is `req_addr[BB-1:0]` (BB = log2 NB) and the row is `req_addr[AW-1:BB]`. In a cycle that issues (`req_valid && req_ready`), `bank_rd_en` has exactly the selected bank's bit set and `bank_row` carries the row. In every other cycle `bank_rd_en` is zero.
- R2: A bank issued in cycle t is not issued again before cycle t+REC.
- R3: When the selected bank was last issued in cycle t and the current cycle c satisfies c-t < REC, `req_ready` is low.
- R4: At most `MAX_OUT` loads are outstanding. A load issued in cycle t counts as outstanding through cycle t+LAT and frees its slot in cycle t+LAT. `req_ready` is high in cycle c only if fewer than `MAX_OUT` issues happened in cycles c-LAT+1 to c-1.
- R5: A load issued in cycle t produces `rsp_valid` in cycle t+LAT+1. `rsp_tag` equals the request tag and `rsp_data` equals the bank's lane value sampled in cycle t+LAT. `rsp_valid` is low in every cycle that has no such due load.
- R6: Responses come out in the order the requests were issued.
- R7: With the defaults (LAT=4, MAX_OUT=3) and no bank conflicts, a unit-stride stream of 12 loads issues its last load 14 cycles after its first.
- R8: `stall_cycles` goes up by one for each cycle in which `req_valid` is high and the selected bank is recovering, whether or not the outstanding limit also blocks that cycle. With 8 banks, REC=6, from idle: 16 loads at stride 1 add 0, 8 loads at stride 2 add 2, 6 loads at stride 4 add 8, 4 loads at stride 8 add 15.
- R9: During reset `rsp_valid` is low. After reset `stall_cycles` is zero, every bank is free and nothing is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | AW | Word address |
| req_tag | input | TGW | Request tag |
| rsp_valid | output | 1 | Response present |
| rsp_tag | output | TGW | Tag of the returned load |
| rsp_data | output | DW | Returned word |
| bank_rd_en | output | NB | Per-bank read strobe |
| bank_row | output | AW-BB | Row address shared by all banks |
| bank_rd_data | input | NB*DW | Per-bank read data lanes, bank b at bits [b*DW +: DW] |
| stall_cycles | output | SCW | Count of bank-conflict cycles |

## Verification
A retirement and a new issue can fall in the same cycle: the oldest load leaves the window just as a new request arrives while the window is full. With LAT=4 and MAX_OUT=3 this happens throughout a unit-stride stream. The scoreboard predicts `req_ready` from the bench's own issue history for every presented request and compares it with the port value. The predicted response cycle and data are matched against the port on every cycle. A second collision, a bank-busy cycle that is also limit-blocked, shows up in the stride-2 run. There the stall counter must count the busy cycle but not the cycle held back only by the limit.

// File: rtl/imb_pkg.sv
// Package: shared defaults for the interleaved multibank load controller.
// Assumes: nothing; holds constants only.
package imb_pkg;
    localparam int unsigned IMB_DEF_NB      = 8;
    localparam int unsigned IMB_DEF_DW      = 64;
    localparam int unsigned IMB_DEF_AW      = 16;
    localparam int unsigned IMB_DEF_TGW     = 6;
    localparam int unsigned IMB_DEF_REC     = 6;
    localparam int unsigned IMB_DEF_LAT     = 4;
    localparam int unsigned IMB_DEF_MAX_OUT = 3;
    localparam int unsigned IMB_DEF_SCW     = 16;
endpackage

// File: rtl/imb_bank_timers.sv
// Module: per-bank recovery down-counters.
// What it does: loading a bank's counter with REC-1 when that bank is accessed;
// the bank reports busy until its counter reaches zero.
// Assumes: REC >= 1; acc is a one-hot-or-zero access strobe.
module imb_bank_timers #(
    parameter int unsigned NB  = 8,
    parameter int unsigned REC = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] acc,
    output logic [NB-1:0] busy
);
    localparam int unsigned TW = (REC < 2) ? 1 : $clog2(REC);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [TW-1:0] cnt;

        // Purpose: reload on access, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (acc[b])     cnt <= TW'(REC - 1);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
        end

        assign busy[b] = (cnt != '0);

        // R2: an access never lands on a bank that is still recovering.
        assert_no_hit_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
            acc[b] |-> (cnt == '0));
    end
endmodule

// File: rtl/imb_inflight.sv
// Module: in-flight load window and in-order return path.
// What it does: following each issued load through a LAT-stage pipe, picking the
// bank's lane at the last stage, registering it onto the response port, and
// limiting the loads in flight to MAX_OUT (a retiring load frees its slot at once).
// Assumes: LAT >= 1; a bank holds its read word until its next access, and
// that next access comes no earlier than LAT cycles later (REC >= LAT).
module imb_inflight #(
    parameter int unsigned NB      = 8,
    parameter int unsigned DW      = 64,
    parameter int unsigned TGW     = 6,
    parameter int unsigned LAT     = 4,
    parameter int unsigned MAX_OUT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [$clog2(NB)-1:0] issue_bank,
    input  logic [TGW-1:0]     issue_tag,
    input  logic [NB*DW-1:0]   bank_rd_data,
    output logic               room,
    output logic               rsp_valid,
    output logic [TGW-1:0]     rsp_tag,
    output logic [DW-1:0]      rsp_data
);
    localparam int unsigned BB = $clog2(NB);
    localparam int unsigned CW = $clog2(MAX_OUT + 1) + 1;

    logic          pv [LAT];
    logic [BB-1:0] pb [LAT];
    logic [TGW-1:0] pt [LAT];
    logic [CW-1:0] cnt;
    logic          retire;

    assign retire = pv[LAT-1];
    assign room   = ((cnt - CW'(retire)) < CW'(MAX_OUT));

    // Purpose: advance the in-flight pipe by one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) pv[i] <= 1'b0;
        end else begin
            pv[0] <= issue;
            for (int i = 1; i < LAT; i++) pv[i] <= pv[i-1];
        end
        pb[0] <= issue_bank;
        pt[0] <= issue_tag;
        for (int i = 1; i < LAT; i++) begin
            pb[i] <= pb[i-1];
            pt[i] <= pt[i-1];
        end
    end

    // Purpose: track the number of loads in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CW'(issue) - CW'(retire);
    end

    // Purpose: register the returning word and tag onto the response port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= retire;
        end
        rsp_tag  <= pt[LAT-1];
        rsp_data <= bank_rd_data[pb[LAT-1]*DW +: DW];
    end

    // R4: the window never holds more than MAX_OUT loads.
    assert_window_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_OUT));
    // R4: a retirement always has a counted load behind it.
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (cnt != '0));
endmodule

// File: rtl/imb_ctrl.sv
// Module: interleaved multibank load controller (top).
// What it does: selecting a bank from the low address bits, issuing a load when
// that bank has recovered and the in-flight window has room, counting
// bank-conflict cycles, and returning data in issue order.
// Assumes: NB is a power of two >= 2; REC >= LAT so bank lanes stay stable.
module imb_ctrl
    import imb_pkg::*;
#(
    parameter int unsigned NB      = IMB_DEF_NB,
    parameter int unsigned DW      = IMB_DEF_DW,
    parameter int unsigned AW      = IMB_DEF_AW,
    parameter int unsigned TGW     = IMB_DEF_TGW,
    parameter int unsigned REC     = IMB_DEF_REC,
    parameter int unsigned LAT     = IMB_DEF_LAT,
    parameter int unsigned MAX_OUT = IMB_DEF_MAX_OUT,
    parameter int unsigned SCW     = IMB_DEF_SCW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [AW-1:0]               req_addr,
    input  logic [TGW-1:0]              req_tag,
    output logic                        rsp_valid,
    output logic [TGW-1:0]              rsp_tag,
    output logic [DW-1:0]               rsp_data,
    output logic [NB-1:0]               bank_rd_en,
    output logic [AW-$clog2(NB)-1:0]    bank_row,
    input  logic [NB*DW-1:0]            bank_rd_data,
    output logic [SCW-1:0]              stall_cycles
);
    localparam int unsigned BB = $clog2(NB);

    logic [BB-1:0] sel;
    logic [NB-1:0] busy;
    logic          room;
    logic          issue;
    logic          conflict;

    // Purpose: decode bank and row, and form the issue decision.
    always_comb begin
        sel        = req_addr[BB-1:0];
        bank_row   = req_addr[AW-1:BB];
        req_ready  = !busy[sel] && room;
        issue      = req_valid && req_ready;
        conflict   = req_valid && busy[sel];
        bank_rd_en = '0;
        if (issue) bank_rd_en[sel] = 1'b1;
    end

    imb_bank_timers #(.NB(NB), .REC(REC)) u_timers (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (bank_rd_en),
        .busy  (busy)
    );

    imb_inflight #(.NB(NB), .DW(DW), .TGW(TGW), .LAT(LAT), .MAX_OUT(MAX_OUT)) u_inflight (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (issue),
        .issue_bank   (sel),
        .issue_tag    (req_tag),
        .bank_rd_data (bank_rd_data),
        .room         (room),
        .rsp_valid    (rsp_valid),
        .rsp_tag      (rsp_tag),
        .rsp_data     (rsp_data)
    );

    // Purpose: count cycles lost to bank conflicts.
    always_ff @(posedge clk) begin
        if (!rst_n)        stall_cycles <= '0;
        else if (conflict) stall_cycles <= stall_cycles + 1'b1;
    end

    // R1: at most one bank strobed per cycle.
    assert_onehot_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_rd_en));
    // R3: a recovering bank holds the request port.
    assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy[sel] |-> !req_ready);
    // R9: reset clears the conflict counter and the response port.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (stall_cycles == '0) && !rsp_valid);
endmodule

// File: tb/imb_ctrl_bench.sv
`timescale 1ns/1ps
module imb_ctrl_bench;
    localparam int NB = 8, DW = 64, AW = 16, TGW = 6, REC = 6, LAT = 4, MAX_OUT = 3, SCW = 16;
    localparam int RW = AW - 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [TGW-1:0] req_tag = '0;
    logic rsp_valid;
    logic [TGW-1:0] rsp_tag;
    logic [DW-1:0] rsp_data;
    logic [NB-1:0] bank_rd_en;
    logic [RW-1:0] bank_row;
    logic [NB*DW-1:0] bank_rd_data = '0;
    logic [SCW-1:0] stall_cycles;

    always #2.5 clk = ~clk;

    imb_ctrl u_imb_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_tag(req_tag), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_data(rsp_data), .bank_rd_en(bank_rd_en),
        .bank_row(bank_row), .bank_rd_data(bank_rd_data), .stall_cycles(stall_cycles)
    );

    function automatic logic [63:0] pat(int b, logic [RW-1:0] row);
        return {8'hC3, 8'(b), 16'(row), 16'(row ^ 13'h1abc), 16'(b * 7 + int'(row))};
    endfunction

    // bank model: lane holds the word of the last row read from that bank
    always @(posedge clk)
        for (int b = 0; b < NB; b++)
            if (bank_rd_en[b]) bank_rd_data[b*DW +: DW] <= pat(b, bank_row);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    bit done = 0;
    int stall_model = 0;
    int last_iss [NB];
    bit last_ok [NB];
    bit issued_at [int];
    int first_iss, last_iss_cyc;

    typedef struct { int due; logic [TGW-1:0] tag; logic [DW-1:0] data; } exp_t;
    exp_t sq [$];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // driver: present one load, hold until issued, push the expected response
    task automatic send(logic [AW-1:0] addr, logic [TGW-1:0] tag);
        int b;
        bit busy_m, exp_rdy;
        int win;
        b = int'(addr[2:0]);
        req_valid = 1'b1; req_addr = addr; req_tag = tag;
        forever begin
            #1;
            busy_m = last_ok[b] && (cyc - last_iss[b] < REC);
            win = 0;
            for (int k = 1; k < LAT; k++) if (issued_at.exists(cyc - k)) win++;
            exp_rdy = !busy_m && (win < MAX_OUT);
            if (busy_m) begin
                stall_model++;
                chk(req_ready == 1'b0, "R3", "ready on busy bank", req_ready, 0);
            end else
                chk(req_ready == exp_rdy, "R4", "ready vs window", req_ready, exp_rdy);
            chk(bank_rd_en == (exp_rdy ? NB'(1 << b) : NB'(0)), "R1", "bank strobe",
                bank_rd_en, exp_rdy ? (1 << b) : 0);
            if (exp_rdy) begin
                chk(bank_row == addr[AW-1:3], "R1", "row", bank_row, addr[AW-1:3]);
                chk(!last_ok[b] || (cyc - last_iss[b] >= REC), "R2", "reissue gap",
                    cyc - last_iss[b], REC);
                sq.push_back('{due: cyc + LAT + 1, tag: tag, data: pat(b, addr[AW-1:3])});
                last_iss[b] = cyc; last_ok[b] = 1'b1; issued_at[cyc] = 1'b1;
                if (first_iss < 0) first_iss = cyc;
                last_iss_cyc = cyc;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic stream(int base, int stride, int n, int exp_stall, string req);
        int s0, m0;
        s0 = int'(stall_cycles); m0 = stall_model; first_iss = -1;
        for (int i = 0; i < n; i++) send(AW'(base + i * stride), TGW'(i));
        repeat (12) begin
            #1; chk(bank_rd_en == '0, "R1", "idle strobe", bank_rd_en, 0);
            @(negedge clk);
        end
        chk(int'(stall_cycles) - s0 == stall_model - m0, "R8", "stall vs model",
            int'(stall_cycles) - s0, stall_model - m0);
        chk(int'(stall_cycles) - s0 == exp_stall, req, "stall count for stride",
            int'(stall_cycles) - s0, exp_stall);
    endtask

    // monitor: compare the response port against the scoreboard every cycle
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk); #2;
            if (sq.size() != 0 && sq[0].due == cyc) begin
                chk(rsp_valid == 1'b1, "R5", "rsp_valid due", rsp_valid, 1);
                chk(rsp_tag == sq[0].tag, "R6", "tag order", rsp_tag, sq[0].tag);
                chk(rsp_data == sq[0].data, "R5", "data", rsp_data, sq[0].data);
                void'(sq.pop_front());
            end else
                chk(rsp_valid == 1'b0, "R5", "rsp_valid idle", rsp_valid, 0);
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin last_ok[b] = 0; last_iss[b] = 0; end
        req_valid = 1'b1; req_addr = '0;
        repeat (3) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R9", "rsp_valid in reset", rsp_valid, 0);
        end
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(stall_cycles == '0, "R9", "stall count after reset", stall_cycles, 0);
        req_valid = 1'b1; req_addr = 16'h0005; #1;
        chk(req_ready == 1'b1, "R9", "bank free after reset", req_ready, 1);
        req_valid = 1'b0;
        @(negedge clk);
        // unit stride: retire and issue share cycles in steady state
        stream(16'h0100, 1, 12, 0, "R8");
        chk(last_iss_cyc - first_iss == 14, "R7", "unit stride span",
            last_iss_cyc - first_iss, 14);
        stream(16'h0200, 1, 16, 0, "R8");
        stream(16'h0400, 2, 8, 2, "R8");
        stream(16'h0600, 4, 6, 8, "R8");
        stream(16'h0800, 8, 4, 15, "R8");
        stream(16'h0A33, 3, 10, -1 + 1 + stall_model * 0, "R6");
        chk(sq.size() == 0, "R6", "all responses returned", sq.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule